// File: doc/BRIEF.md
# Sync-Monitoring Clamp Pulse Generator

This block places a back-porch clamp pulse for a video front end. It watches a composite sync input, counted in sample clocks at four times the colour subcarrier. It accepts a sync falling edge only inside a window near the expected line start, and it confirms a sync tip only when the input is still low when a fixed check delay ends. A short clamp delay follows each confirmed sync rising edge, and then the clamp pulse is driven.

A free-running line counter keeps the line phase. When a line brings no confirmed sync, the counter still emits the clamp pulse at a fixed count after its zero point. The clamp stays correctly placed through missing pulses, early pulses and noise spikes. A standard select picks the NTSC or PAL line length and interval set. When the internal mode is deselected, the counters are held idle and the input is passed through as an active-high external clamp pulse. Two window signals are brought out for debug.

Top module: `clamp_pulse_gen`

## Requirements
- R1: After reset, clamp_out is 0, fall_gate is 0 and rise_gate is 1. In internal mode, no clamp pulse is produced before the first sync falling edge, however long the input stays high.
- R2: csync_in passes through a two-flop synchronizer. Edges are taken from the synchronized level, so an edge driven on the input acts at the third rising clock edge that follows.
- R3: std_pal low selects NTSC: the line is 910 clocks, the window opens at count 867 and lasts 43, the clamp pulse is 54 wide and the flywheel point is 76. std_pal high selects PAL: the line is 1136, the window opens at 1075 and lasts 61, the pulse is 84 wide and the flywheel point is 93.
- R4: The first sync falling edge after reset locks the block and sets the line counter to zero. Without a further accepted edge, the counter wraps to zero after one full line length.
- R5: Once locked, a falling edge is accepted only while the counter is inside the window. fall_gate is high for exactly those counts. A falling edge at a lower count is ignored and leaves the counter phase unchanged.
- R6: After every accepted falling edge, rise_gate is low for 58 clocks. When it returns high, the synchronized input is sampled: low confirms the sync tip, and high marks the pulse as noise, which is then ignored.
- R7: When a rising edge follows a confirmed sync tip, clamp_out goes high 6 clocks after that edge and stays high for the pulse width of the selected standard.
- R8: In a line with no confirmed sync tip, clamp_out goes high while the counter equals the flywheel point and stays high for the selected pulse width. This repeats every line for as long as sync stays absent.
- R9: With clamp_int_en low, clamp_out equals csync_in delayed by two clocks. fall_gate stays 0, rise_gate stays 1, and no internal clamp pulse is produced.
- R10: With clamp_int_en low and csync_in held low, clamp_out stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, four times the colour subcarrier |
| rst_n | input | 1 | Active-low synchronous reset |
| csync_in | input | 1 | Composite sync (internal mode) or external clamp pulse (external mode) |
| clamp_int_en | input | 1 | 1: internal sync-derived clamp; 0: external pass-through |
| std_pal | input | 1 | 0: NTSC timing; 1: PAL timing |
| clamp_out | output | 1 | Active-high clamp pulse |
| fall_gate | output | 1 | High while a sync falling edge would be accepted |
| rise_gate | output | 1 | Low during the 58-clock tip check after an accepted falling edge |

## Verification
Each result has a fixed due cycle. An input edge driven at clock n reaches the edge detector at the edge n+3, and that edge is the counter's zero point. The window then opens on count 867 or 1075 and rise_gate returns high 58 clocks after the zero point. A sync-derived clamp starts 9 clocks after its rising edge is driven, and a flywheel clamp starts at the zero point plus 76 or 93. In external mode, clamp_out follows the input 2 clocks later. The bench schedules every input change on an absolute cycle number and computes these due cycles from it. It samples levels at the falling clock edge of that exact cycle and checks one cycle on each side of every window boundary. Pulse start cycles and widths are recorded by a monitor and compared with the computed values.

// File: rtl/clpg_pkg.sv
package clpg_pkg;
  typedef enum logic {
    STD_NTSC = 1'b0,
    STD_PAL  = 1'b1
  } vid_std_e;

  localparam int NTSC_LINE_DEF  = 910;
  localparam int PAL_LINE_DEF   = 1136;
  localparam int NTSC_WOPEN_DEF = 867;
  localparam int PAL_WOPEN_DEF  = 1075;
  localparam int NTSC_WLEN_DEF  = 43;
  localparam int PAL_WLEN_DEF   = 61;
  localparam int TIP_CHECK_DEF  = 58;
  localparam int CLAMP_DLY_DEF  = 6;
  localparam int NTSC_CLW_DEF   = 54;
  localparam int PAL_CLW_DEF    = 84;
  localparam int NTSC_FLY_DEF   = 76;
  localparam int PAL_FLY_DEF    = 93;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/clpg_edge_sync.sv
module clpg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic fall,
  output logic rise
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], din};
  end

  assign level = pipe[STAGES-1];
  assign fall  = pipe[STAGES] & ~pipe[STAGES-1];
  assign rise  = ~pipe[STAGES] & pipe[STAGES-1];
endmodule

// File: rtl/clpg_line_timer.sv
module clpg_line_timer #(
  parameter int N_LINE   = 910,
  parameter int P_LINE   = 1136,
  parameter int N_WOPEN  = 867,
  parameter int P_WOPEN  = 1075,
  parameter int N_WLEN   = 43,
  parameter int P_WLEN   = 61,
  parameter int TIP_CHK  = 58,
  parameter int N_FLY    = 76,
  parameter int P_FLY    = 93,
  parameter int CW       = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic pal,
  input  logic level,
  input  logic fall,
  input  logic rise,
  output logic win_open,
  output logic tip_wait,
  output logic fire,
  output logic fire_delayed
);
  localparam logic [CW-1:0] N_LAST = CW'(N_LINE - 1);
  localparam logic [CW-1:0] P_LAST = CW'(P_LINE - 1);
  localparam logic [CW-1:0] N_WLO  = CW'(N_WOPEN);
  localparam logic [CW-1:0] P_WLO  = CW'(P_WOPEN);
  localparam logic [CW-1:0] N_WHI  = CW'(N_WOPEN + N_WLEN - 1);
  localparam logic [CW-1:0] P_WHI  = CW'(P_WOPEN + P_WLEN - 1);
  localparam logic [CW-1:0] N_FAT  = CW'(N_FLY - 1);
  localparam logic [CW-1:0] P_FAT  = CW'(P_FLY - 1);
  localparam logic [CW-1:0] CHK_AT = CW'(TIP_CHK - 1);

  logic [CW-1:0] cnt;
  logic          locked;
  logic          gate_act;
  logic          tip_ok;
  logic          served;

  logic [CW-1:0] last_c, wlo_c, whi_c, fat_c;
  logic          accept, wrap, fly_hit, rise_hit;

  always_comb begin
    last_c   = pal ? P_LAST : N_LAST;
    wlo_c    = pal ? P_WLO  : N_WLO;
    whi_c    = pal ? P_WHI  : N_WHI;
    fat_c    = pal ? P_FAT  : N_FAT;
    win_open = locked && (cnt >= wlo_c) && (cnt <= whi_c);
    accept   = fall && (!locked || win_open);
    wrap     = locked && (cnt >= last_c);
    rise_hit = rise && tip_ok && !accept;
    fly_hit  = locked && !accept && !tip_ok && !served && (cnt == fat_c);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt      <= '0;
      locked   <= 1'b0;
      gate_act <= 1'b0;
      tip_ok   <= 1'b0;
      served   <= 1'b0;
    end else if (accept) begin
      cnt      <= '0;
      locked   <= 1'b1;
      gate_act <= 1'b1;
      tip_ok   <= 1'b0;
      served   <= 1'b0;
    end else begin
      if (locked) cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap) begin
        tip_ok <= 1'b0;
        served <= 1'b0;
      end
      if (gate_act && cnt == CHK_AT) begin
        gate_act <= 1'b0;
        tip_ok   <= ~level;
      end
      if (rise_hit) begin
        tip_ok <= 1'b0;
        served <= 1'b1;
      end
      if (fly_hit) served <= 1'b1;
    end
  end

  assign tip_wait     = gate_act;
  assign fire         = rise_hit | fly_hit;
  assign fire_delayed = rise_hit;
endmodule

// File: rtl/clpg_pulse_shaper.sv
module clpg_pulse_shaper #(
  parameter int DELAY = 6,
  parameter int N_W   = 54,
  parameter int P_W   = 84,
  parameter int SW    = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic pal,
  input  logic fire,
  input  logic use_delay,
  output logic pulse
);
  localparam logic [SW-1:0] D_SYNC = SW'(DELAY);
  localparam logic [SW-1:0] W_NTSC = SW'(N_W);
  localparam logic [SW-1:0] W_PAL  = SW'(P_W);

  logic [SW-1:0] ph;
  logic          dsel;
  logic [SW-1:0] d_cur, lim;

  always_comb begin
    d_cur = dsel ? D_SYNC : '0;
    lim   = d_cur + (pal ? W_PAL : W_NTSC);
    pulse = (ph > d_cur) && (ph <= lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      ph   <= '0;
      dsel <= 1'b0;
    end else if (fire) begin
      ph   <= SW'(1);
      dsel <= use_delay;
    end else if (ph != '0) begin
      ph <= (ph >= lim) ? '0 : ph + 1'b1;
    end
  end
endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
  import clpg_pkg::*;
#(
  parameter int N_LINE    = NTSC_LINE_DEF,
  parameter int P_LINE    = PAL_LINE_DEF,
  parameter int N_WOPEN   = NTSC_WOPEN_DEF,
  parameter int P_WOPEN   = PAL_WOPEN_DEF,
  parameter int N_WLEN    = NTSC_WLEN_DEF,
  parameter int P_WLEN    = PAL_WLEN_DEF,
  parameter int TIP_CHK   = TIP_CHECK_DEF,
  parameter int CLAMP_DLY = CLAMP_DLY_DEF,
  parameter int N_CLW     = NTSC_CLW_DEF,
  parameter int P_CLW     = PAL_CLW_DEF,
  parameter int N_FLY     = NTSC_FLY_DEF,
  parameter int P_FLY     = PAL_FLY_DEF,
  parameter int SYNC_FF   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_in,
  input  logic clamp_int_en,
  input  logic std_pal,
  output logic clamp_out,
  output logic fall_gate,
  output logic rise_gate
);
  localparam int CW = $clog2(max_of(N_LINE, P_LINE) + 1);
  localparam int SW = $clog2(CLAMP_DLY + max_of(N_CLW, P_CLW) + 2);

  vid_std_e std;
  logic     pal;
  logic     s_lvl, s_fall, s_rise;
  logic     win_open, tip_wait, fire, fire_delayed, shaped;

  assign std = vid_std_e'(std_pal);
  assign pal = (std == STD_PAL);

  clpg_edge_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (csync_in),
    .level (s_lvl),
    .fall  (s_fall),
    .rise  (s_rise)
  );

  clpg_line_timer #(
    .N_LINE (N_LINE),  .P_LINE (P_LINE),
    .N_WOPEN(N_WOPEN), .P_WOPEN(P_WOPEN),
    .N_WLEN (N_WLEN),  .P_WLEN (P_WLEN),
    .TIP_CHK(TIP_CHK),
    .N_FLY  (N_FLY),   .P_FLY  (P_FLY),
    .CW     (CW)
  ) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .run          (clamp_int_en),
    .pal          (pal),
    .level        (s_lvl),
    .fall         (s_fall),
    .rise         (s_rise),
    .win_open     (win_open),
    .tip_wait     (tip_wait),
    .fire         (fire),
    .fire_delayed (fire_delayed)
  );

  clpg_pulse_shaper #(
    .DELAY (CLAMP_DLY),
    .N_W   (N_CLW),
    .P_W   (P_CLW),
    .SW    (SW)
  ) u_shape (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (clamp_int_en),
    .pal       (pal),
    .fire      (fire),
    .use_delay (fire_delayed),
    .pulse     (shaped)
  );

  assign clamp_out = clamp_int_en ? shaped : s_lvl;
  assign fall_gate = win_open;
  assign rise_gate = ~tip_wait;
endmodule

// File: rtl/clpg_chk.sv
module clpg_chk #(
  parameter int N_W      = 54,
  parameter int P_W      = 84,
  parameter int GATE_LEN = 58
) (
  input logic clk,
  input logic rst_n,
  input logic csync_in,
  input logic clamp_int_en,
  input logic std_pal,
  input logic clamp_out,
  input logic fall_gate,
  input logic rise_gate
);
  logic [1:0]  ext_age;
  logic [15:0] hi_run;
  logic [15:0] lo_run;
  logic        armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_age <= '0;
      hi_run  <= '0;
      lo_run  <= '0;
      armed   <= 1'b0;
    end else begin
      if (clamp_int_en)        ext_age <= '0;
      else if (ext_age != 2'd3) ext_age <= ext_age + 1'b1;
      if (!clamp_int_en)   armed <= 1'b0;
      else if (!clamp_out) armed <= 1'b1;
      hi_run <= (clamp_int_en && clamp_out) ? hi_run + 1'b1 : '0;
      lo_run <= (!rise_gate) ? lo_run + 1'b1 : '0;
    end
  end

  // R9
  ext_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clamp_int_en && ext_age == 2'd3) |-> (clamp_out == $past(csync_in, 2)));

  // R9
  ext_gates_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clamp_int_en && ext_age != 2'd0) |-> (!fall_gate && rise_gate));

  // R7
  clamp_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && clamp_int_en && $past(clamp_int_en) && $fell(clamp_out))
      |-> (hi_run == 16'(std_pal ? P_W : N_W)));

  // R6
  tip_gate_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_int_en && $past(clamp_int_en) && $rose(rise_gate))
      |-> (lo_run == 16'(GATE_LEN)));
endmodule

bind clamp_pulse_gen clpg_chk #(
  .N_W      (N_CLW),
  .P_W      (P_CLW),
  .GATE_LEN (TIP_CHK)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .csync_in     (csync_in),
  .clamp_int_en (clamp_int_en),
  .std_pal      (std_pal),
  .clamp_out    (clamp_out),
  .fall_gate    (fall_gate),
  .rise_gate    (rise_gate)
);

// File: tb/clamp_pulse_gen_tb.sv
module clamp_pulse_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csync_in = 1'b1;
  logic clamp_int_en = 1'b1;
  logic std_pal = 1'b0;
  logic clamp_out, fall_gate, rise_gate;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int rise_cnt = 0;
  int last_rise = -1;
  int last_width = -1;
  logic prev_cl = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  clamp_pulse_gen u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .csync_in     (csync_in),
    .clamp_int_en (clamp_int_en),
    .std_pal      (std_pal),
    .clamp_out    (clamp_out),
    .fall_gate    (fall_gate),
    .rise_gate    (rise_gate)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      rise_cnt = 0;
      prev_cl  = 1'b0;
    end else begin
      if (clamp_out && !prev_cl) begin
        rise_cnt++;
        last_rise = cyc;
      end
      if (!clamp_out && prev_cl) last_width = cyc - last_rise;
      prev_cl = clamp_out;
    end
  end

  task automatic chk_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_until(input int c);
    forever begin
      @(negedge clk);
      if (cyc >= c) break;
    end
  endtask

  task automatic drive_at(input int c, input logic v);
    wait_until(c);
    csync_in = v;
  endtask

  task automatic do_reset(input logic intm, input logic pal, input logic idle);
    @(negedge clk);
    rst_n = 1'b0;
    clamp_int_en = intm;
    std_pal = pal;
    csync_in = idle;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // R1: reset state, no clamp before lock
  task automatic t_reset_idle();
    int n;
    do_reset(1'b1, 1'b0, 1'b1);
    chk_eq("R1 clamp_out after reset", int'(clamp_out), 0);
    chk_eq("R1 fall_gate after reset", int'(fall_gate), 0);
    chk_eq("R1 rise_gate after reset", int'(rise_gate), 1);
    n = cyc;
    wait_until(n + 1500);
    chk_eq("R1 no clamp before first falling edge", rise_cnt, 0);
  endtask

  // R2 R3 R4 R5 R6 R7 R8: NTSC lock, regular line, early spike, flywheel
  task automatic t_ntsc_run();
    int n, e0;
    do_reset(1'b1, 1'b0, 1'b1);
    n = cyc + 5;
    e0 = n + 3;                       // R2: third edge after the driven edge
    drive_at(n, 1'b0);
    wait_until(e0 + 57);
    chk_eq("R6 rise_gate low at last tip-check cycle", int'(rise_gate), 0);
    wait_until(e0 + 58);
    chk_eq("R6 rise_gate high after 58 clocks", int'(rise_gate), 1);
    drive_at(n + 67, 1'b1);
    wait_until(n + 200);
    chk_eq("R7 clamp start after confirmed sync", last_rise, n + 67 + 3 + 6);
    chk_eq("R3 R7 NTSC clamp width", last_width, 54);
    chk_eq("R7 single clamp in synced line", rise_cnt, 1);
    wait_until(e0 + 866);
    chk_eq("R5 fall_gate low before window", int'(fall_gate), 0);
    wait_until(e0 + 867);
    chk_eq("R3 R5 fall_gate high at NTSC window open", int'(fall_gate), 1);
    // second line, sync exactly one line later
    drive_at(n + 910, 1'b0);
    drive_at(n + 977, 1'b1);
    wait_until(n + 1100);
    chk_eq("R4 R5 clamp on regular second line", last_rise, n + 910 + 76);
    chk_eq("R7 clamp count after second line", rise_cnt, 2);
    // early wide pulse, must be ignored
    drive_at(n + 1310, 1'b0);
    drive_at(n + 1390, 1'b1);
    wait_until(n + 1500);
    chk_eq("R5 early falling edge makes no clamp", rise_cnt, 2);
    drive_at(n + 1820, 1'b0);
    drive_at(n + 1887, 1'b1);
    wait_until(n + 2000);
    chk_eq("R5 phase kept after early edge", last_rise, n + 1820 + 76);
    // sync now missing: flywheel
    wait_until(n + 2900);
    chk_eq("R4 R8 first flywheel clamp", last_rise, n + 1823 + 910 + 76);
    chk_eq("R8 flywheel clamp width", last_width, 54);
    wait_until(n + 3800);
    chk_eq("R8 second flywheel clamp", last_rise, n + 1823 + 1820 + 76);
    chk_eq("R8 flywheel clamp count", rise_cnt, 5);
  endtask

  // R6: short pulse inside the window is noise
  task automatic t_window_noise();
    int n;
    do_reset(1'b1, 1'b0, 1'b1);
    n = cyc + 5;
    drive_at(n, 1'b0);
    drive_at(n + 67, 1'b1);
    drive_at(n + 900, 1'b0);
    drive_at(n + 920, 1'b1);
    wait_until(n + 1100);
    chk_eq("R6 noise tip gives flywheel clamp", last_rise, n + 903 + 76);
    chk_eq("R6 noise rise makes no extra clamp", rise_cnt, 2);
  endtask

  // R5: window boundary, one cycle each side
  task automatic t_window_edge(input int off, input bit accepted);
    int n;
    do_reset(1'b1, 1'b0, 1'b1);
    n = cyc + 5;
    drive_at(n, 1'b0);
    drive_at(n + 67, 1'b1);
    drive_at(n + off, 1'b0);
    wait_until(n + 880);
    chk_eq("R5 R6 rise_gate shows edge acceptance", int'(rise_gate), accepted ? 0 : 1);
    drive_at(n + off + 67, 1'b1);
    wait_until(n + 1100);
    if (accepted)
      chk_eq("R5 edge at window open accepted", last_rise, n + off + 67 + 9);
    else
      chk_eq("R5 edge before window ignored", last_rise, n + 913 + 76);
  endtask

  // R3: PAL timing
  task automatic t_pal();
    int n, e0;
    do_reset(1'b1, 1'b1, 1'b1);
    n = cyc + 5;
    e0 = n + 3;
    drive_at(n, 1'b0);
    drive_at(n + 67, 1'b1);
    wait_until(n + 200);
    chk_eq("R3 R7 PAL clamp start", last_rise, n + 76);
    chk_eq("R3 PAL clamp width", last_width, 84);
    wait_until(e0 + 1074);
    chk_eq("R3 PAL window closed", int'(fall_gate), 0);
    wait_until(e0 + 1075);
    chk_eq("R3 PAL window open", int'(fall_gate), 1);
    wait_until(n + 1400);
    chk_eq("R3 R8 PAL flywheel start", last_rise, e0 + 1136 + 93);
    chk_eq("R3 R8 PAL flywheel width", last_width, 84);
  endtask

  // R9 R10: external pass-through
  task automatic t_external();
    int m;
    do_reset(1'b0, 1'b0, 1'b0);
    m = cyc + 30;
    wait_until(m);
    chk_eq("R10 no clamp with low input", int'(clamp_out), 0);
    chk_eq("R10 no clamp pulses seen", rise_cnt, 0);
    chk_eq("R9 fall_gate idle", int'(fall_gate), 0);
    chk_eq("R9 rise_gate idle", int'(rise_gate), 1);
    drive_at(m + 5, 1'b1);
    drive_at(m + 15, 1'b0);
    wait_until(m + 300);
    chk_eq("R9 pass-through start", last_rise, m + 7);
    chk_eq("R9 pass-through width", last_width, 10);
    chk_eq("R9 no internal clamp", rise_cnt, 1);
  endtask

  function automatic void report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endfunction

  initial begin
    t_reset_idle();
    t_ntsc_run();
    t_window_noise();
    t_window_edge(867, 1'b0);
    t_window_edge(868, 1'b1);
    t_pal();
    t_external();
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      report();
      $finish;
    end
  end
endmodule